// File: doc/BRIEF.md
# Single-Bit Test and Modify Unit

This unit performs one single-bit operation on a data word in each accepted request. A bit index picks one position of the word. The value held at that position before any change is returned as a carry flag. An operation code then chooses what happens to that bit. It can be left alone, forced to one, forced to zero or inverted. The modified word is returned for writeback, together with a write-enable that marks whether writeback is needed.

The operand size can be 16, 32 or 64 bits. The bit index is wrapped to the active size, so an index past the top of the operand folds back into it. Bits of the word above the active size are never touched. Every result is registered and appears one clock cycle after the input strobe.

Top module: `bit_op_unit`

## Requirements
- R1: While reset is held, and in the cycle after it is released, out_valid, out_wen and out_carry are 0 and out_result is all zeros.
- R2: out_carry equals the bit of in_data at the effective index, sampled before any modification.
- R3: Operation codes are 0 = test, 1 = set, 2 = clear, 3 = complement; with code 1 the selected bit of out_result is 1.
- R4: With code 2 the selected bit of out_result is 0.
- R5: With code 3 the selected bit of out_result is the inverse of the input bit.
- R6: With code 0, out_result equals in_data and out_wen is 0; with any other code out_wen is 1.
- R7: Size codes are 0 = 16 bits, 1 = 32 bits, 2 or 3 = 64 bits; the effective index is in_index modulo the size (its low 4, 5 or 6 bits) and higher index bits have no effect.
- R8: Every bit of out_result other than the selected one equals in_data, including all bits above the active operand size.
- R9: out_valid is 1 exactly one cycle after in_valid is 1; after a cycle with in_valid low, out_valid and out_wen are 0 and out_carry and out_result hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_size | input | 2 | Operand size code |
| in_data | input | 64 | Data word |
| in_index | input | 8 | Bit index |
| in_op | input | 2 | Operation code |
| out_valid | output | 1 | Result valid |
| out_carry | output | 1 | Original value of the selected bit |
| out_result | output | 64 | Word after the modification |
| out_wen | output | 1 | Writeback required |

## Verification
The bench builds the unit with its defaults: a 64-bit data path and an 8-bit index. With these, an index can exceed every operand size. That brings wrap-around within reach for all three sizes, for example index 16 with the 16-bit size, index 32 with the 32-bit size and index 200 with the 64-bit size. The 64-bit path also leaves 48 or 32 upper bits above the smaller sizes, so the bench can confirm that random patterns there pass through unchanged.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
    typedef enum logic [1:0] {
        BOP_TEST = 2'd0,
        BOP_SET  = 2'd1,
        BOP_CLR  = 2'd2,
        BOP_FLIP = 2'd3
    } bop_op_e;

    typedef enum logic [1:0] {
        BSZ_16  = 2'd0,
        BSZ_32  = 2'd1,
        BSZ_64  = 2'd2,
        BSZ_64B = 2'd3
    } bop_size_e;
endpackage

// File: rtl/bitop_sel.sv
module bitop_sel #(
    parameter int DATA_W = 64,
    parameter int IDX_W  = 8
) (
    input  logic [1:0]        size,
    input  logic [IDX_W-1:0]  index,
    output logic [DATA_W-1:0] mask
);
    import bitop_pkg::*;

    logic [IDX_W-1:0] limit;
    logic [IDX_W-1:0] eff;

    always_comb begin
        case (bop_size_e'(size))
            BSZ_16:  limit = IDX_W'(15);
            BSZ_32:  limit = IDX_W'(31);
            default: limit = IDX_W'(DATA_W - 1);
        endcase
        eff = index & limit;
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign mask[i] = (eff == IDX_W'(i));
    end
endmodule

// File: rtl/bitop_apply.sv
module bitop_apply #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] mask,
    input  logic [1:0]        op,
    output logic              carry,
    output logic              wen,
    output logic [DATA_W-1:0] result
);
    import bitop_pkg::*;

    always_comb begin
        carry = |(data & mask);
        wen   = 1'b1;
        case (bop_op_e'(op))
            BOP_SET:  result = data | mask;
            BOP_CLR:  result = data & ~mask;
            BOP_FLIP: result = data ^ mask;
            default: begin
                result = data;
                wen    = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/bit_op_unit.sv
module bit_op_unit #(
    parameter int DATA_W = 64,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_size,
    input  logic [DATA_W-1:0] in_data,
    input  logic [IDX_W-1:0]  in_index,
    input  logic [1:0]        in_op,
    output logic              out_valid,
    output logic              out_carry,
    output logic [DATA_W-1:0] out_result,
    output logic              out_wen
);
    typedef struct packed {
        logic              valid;
        logic              carry;
        logic              wen;
        logic [DATA_W-1:0] result;
    } state_t;

    state_t st_d, st_q;
    logic [DATA_W-1:0] mask;
    logic              carry_c, wen_c;
    logic [DATA_W-1:0] result_c;

    bitop_sel #(.DATA_W(DATA_W), .IDX_W(IDX_W)) sel_i (
        .size (in_size),
        .index(in_index),
        .mask (mask)
    );

    bitop_apply #(.DATA_W(DATA_W)) apply_i (
        .data  (in_data),
        .mask  (mask),
        .op    (in_op),
        .carry (carry_c),
        .wen   (wen_c),
        .result(result_c)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        st_d.wen   = 1'b0;
        if (in_valid) begin
            st_d.carry  = carry_c;
            st_d.wen    = wen_c;
            st_d.result = result_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.valid;
    assign out_carry  = st_q.carry;
    assign out_wen    = st_q.wen;
    assign out_result = st_q.result;

    // R9: one-cycle latency of the valid strobe
    a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_wen && $stable(out_result)));
    // R6: test leaves the word intact with no write
    a_r6_test_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'd0) |=> (!out_wen && out_result == $past(in_data)));
    // R3 and R8: set only raises at most one bit
    a_r3_set_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'd1) |=>
        (((out_result & $past(in_data)) == $past(in_data)) &&
         ($countones(out_result ^ $past(in_data)) <= 1)));
    // R5: complement always changes exactly one bit
    a_r5_flip_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'd3) |=> ($countones(out_result ^ $past(in_data)) == 1));
    // R8: upper bits untouched for 16-bit operands
    a_r8_upper_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_size == 2'd0) |=> (out_result[DATA_W-1:16] == $past(in_data[DATA_W-1:16])));
endmodule

// File: tb/bit_op_unit_tb_top.sv
module bit_op_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_size = '0;
    logic [63:0] in_data = '0;
    logic [7:0]  in_index = '0;
    logic [1:0]  in_op = '0;
    logic        out_valid, out_carry, out_wen;
    logic [63:0] out_result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bit_op_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_size(in_size),
        .in_data(in_data), .in_index(in_index), .in_op(in_op),
        .out_valid(out_valid), .out_carry(out_carry),
        .out_result(out_result), .out_wen(out_wen)
    );

    function automatic int eff_idx(logic [1:0] sz, logic [7:0] idx);
        if (sz == 2'd0) return int'(idx) % 16;
        if (sz == 2'd1) return int'(idx) % 32;
        return int'(idx) % 64;
    endfunction

    function automatic logic [63:0] ref_result(logic [1:0] sz, logic [63:0] d,
                                               logic [7:0] idx, logic [1:0] op);
        logic [63:0] r = d;
        int k = eff_idx(sz, idx);
        case (op)
            2'd1: r[k] = 1'b1;
            2'd2: r[k] = 1'b0;
            2'd3: r[k] = ~d[k];
            default: r = d;
        endcase
        return r;
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(logic [1:0] sz, logic [63:0] d, logic [7:0] idx,
                          logic [1:0] op, string req);
        logic [63:0] er = ref_result(sz, d, idx, op);
        logic ec = d[eff_idx(sz, idx)];
        @(negedge clk);
        in_valid = 1'b1; in_size = sz; in_data = d; in_index = idx; in_op = op;
        @(negedge clk);
        in_valid = 1'b0; in_data = ~d;
        check(out_valid == 1'b1, {req, " R9 valid"}, 64'(out_valid), 64'd1);
        check(out_carry == ec, {req, " R2 carry"}, 64'(out_carry), 64'(ec));
        check(out_result == er, {req, " R8 result"}, out_result, er);
        check(out_wen == (op != 2'd0), {req, " R6 wen"}, 64'(out_wen), 64'(op != 2'd0));
        @(negedge clk);
        check(!out_valid && !out_wen, "R9 idle", {62'd0, out_valid, out_wen}, 64'd0);
        check(out_result == er && out_carry == ec, "R9 hold", out_result, er);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!out_valid && !out_wen && !out_carry && out_result == 0, "R1 reset",
              out_result, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && !out_wen && !out_carry && out_result == 0, "R1 after release",
              out_result, 64'd0);
        // directed corners
        run_op(2'd0, 64'hFFFF_0000_1234_0001, 8'd0,   2'd0, "R6 test");
        run_op(2'd0, 64'hA5A5_A5A5_A5A5_0000, 8'd15,  2'd1, "R3 set b15");
        run_op(2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 8'd16,  2'd2, "R7 wrap16 R4");
        run_op(2'd1, 64'h0000_0001_0000_0001, 8'd32,  2'd3, "R7 wrap32 R5");
        run_op(2'd2, 64'h8000_0000_0000_0000, 8'd63,  2'd2, "R4 clr b63");
        run_op(2'd3, 64'h0000_0000_0000_0000, 8'd200, 2'd1, "R7 idx200 R3");
        run_op(2'd1, 64'hFFFF_FFFF_0000_0000, 8'd31,  2'd3, "R5 R8 upper");
        run_op(2'd0, 64'h1234_5678_9ABC_DEF0, 8'd255, 2'd3, "R7 idx255");
        // random
        void'($urandom(32'd12345));
        for (int i = 0; i < 300; i++) begin
            run_op(2'($urandom), {$urandom, $urandom}, 8'($urandom), 2'($urandom), "R2 rnd");
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule